// File: doc/BRIEF.md
# Packed Pixel Frame Store with Priority Writes

This block is a frame store for 4-bit pixels packed four to a 16-bit memory word. A bus master sends requests over a valid/ready channel. Each request carries a byte address, a size flag, write data and a two-bit priority mode. One byte address selects one pixel. Word accesses cover a pair of neighbouring pixels.

A write is a read-modify-write of the containing word. The stored pixel is read in the first cycle. The new word is written back in the second cycle. The priority mode can suppress a pixel update:
- **Overwrite** mode lets a transparent (zero) pixel leave the picture untouched.
- **Underwrite** mode only fills pixels that are still zero.

A read returns pixels spread out so that each byte holds one pixel in its low nibble. Read data leaves on a second valid/ready channel.

Back-pressure rules:
- The request channel accepts one transaction at a time. `req_ready` is high only while the block is idle.
- A read response is held, unchanged, until the master raises `rsp_ready`. No new request is taken while the response is held.
- Writes produce no response.

Top module: `ppr_frame_store`

## Requirements
- R1: A byte address `a` selects word `a >> 2` and pixel `p = a & 3`. Pixel p occupies bits `15-4p` down to `12-4p` of the word, so pixel 0 is bits 15:12. A pixel write changes only its own nibble, including in the last word of the memory.
- R2: A pixel write stores only the low 4 bits of its data byte.
- R3: With priority mode 2'b00, or with mode 2'b11, every pixel write is applied, including a write of zero.
- R4: With priority mode 2'b10 (overwrite), a pixel write of zero is dropped and nonzero values are stored.
- R5: With priority mode 2'b01 (underwrite), a pixel write is dropped when the new value is zero or when the stored pixel is nonzero.
- R6: A word write (`req_wide`=1) ignores address bit 0. It writes `req_wdata[11:8]` to pixel `2*a[1]` and `req_wdata[3:0]` to pixel `2*a[1]+1`. Each pixel is judged separately under the priority mode.
- R7: A word read ignores address bit 0. It returns pixel `2*a[1]` in bits 11:8 and pixel `2*a[1]+1` in bits 3:0, with all other bits zero.
- R8: A byte read returns the addressed pixel in `rsp_rdata[3:0]`, with bits 15:4 zero.
- R9: `req_ready` is high only when idle. After an accepted write, `req_ready` is low for exactly one cycle. After an accepted read, `rsp_valid` rises on the second clock edge after acceptance.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay unchanged and `req_ready` stays low.
- R11: During and after reset, `req_ready` is 1 and `rsp_valid` is 0. Memory contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Byte address (one pixel per byte) |
| req_wdata | input | 16 | Write data |
| req_prio | input | 2 | Priority mode, sampled with the request: 01 underwrite, 10 overwrite, 00/11 plain |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Master takes the read data |
| rsp_rdata | output | 16 | Expanded read data |

## Verification
The hardest case to reach is underwrite on a word write where the two pixels of the pair take opposite decisions. One pixel must start at zero and be filled, while its neighbour already holds a value and must keep it. The stimulus reaches this in two steps. A plain-mode word write first plants a zero and a nonzero pixel side by side. An underwrite word write with two nonzero values then hits that pair, and a word read exposes both decisions at once. A held response with `rsp_ready` low is forced in a separate directed test.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int PIX_W  = 4;
  localparam int LANES  = 4;
  localparam int WORD_W = PIX_W * LANES;

  typedef enum logic [1:0] {
    PRIO_PLAIN = 2'b00,
    PRIO_UNDER = 2'b01,
    PRIO_OVER  = 2'b10,
    PRIO_BOTH  = 2'b11
  } prio_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  function automatic logic [PIX_W-1:0] pix_at(input logic [WORD_W-1:0] w,
                                              input logic [1:0] lane);
    int hi;
    hi = WORD_W - 1 - PIX_W * int'(lane);
    return w[hi -: PIX_W];
  endfunction
endpackage

// File: rtl/ppr_word_store.sv
module ppr_word_store #(
  parameter int WORDS  = 256,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
    if (rd_en) rd_word <= mem[rd_idx];
  end

  // R9: a fetch and a write-back never share a cycle
  always_ff @(posedge clk) begin
    assert_rw_exclusive_R9: assert (!(rd_en && wr_en))
      else $error("fetch and write-back in the same cycle");
  end
endmodule

// File: rtl/ppr_pix_merge.sv
module ppr_pix_merge
  import ppr_pkg::*;
(
  input  prio_e             mode,
  input  logic              sel,
  input  logic [PIX_W-1:0]  old_pix,
  input  logic [PIX_W-1:0]  new_pix,
  output logic [PIX_W-1:0]  out_pix
);
  logic new_zero, old_set, keep;

  always_comb begin
    new_zero = (new_pix == '0);
    old_set  = (old_pix != '0);
    unique case (mode)
      PRIO_OVER:  keep = new_zero;
      PRIO_UNDER: keep = new_zero || old_set;
      default:    keep = 1'b0;
    endcase
    out_pix = (!sel || keep) ? old_pix : new_pix;
  end
endmodule

// File: rtl/ppr_read_expand.sv
module ppr_read_expand
  import ppr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  input  logic              wide,
  output logic [15:0]       data
);
  logic [1:0] lane_hi, lane_lo;

  always_comb begin
    lane_hi = {lane[1], 1'b0};
    lane_lo = {lane[1], 1'b1};
    if (wide)
      data = {4'h0, pix_at(word, lane_hi), 4'h0, pix_at(word, lane_lo)};
    else
      data = {12'h000, pix_at(word, lane)};
  end
endmodule

// File: rtl/ppr_frame_store.sv
module ppr_frame_store
  import ppr_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_prio,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata
);
  state_e             st;
  logic               wr_q, wide_q;
  logic [1:0]         lane_q;
  logic [IDX_W-1:0]   idx_q;
  logic [15:0]        wdata_q;
  prio_e              mode_q;
  logic [15:0]        rdata_q;

  logic               accept;
  logic               wb_en;
  logic [WORD_W-1:0]  old_word, wb_word;
  logic [15:0]        rd_expanded;
  logic [LANES-1:0]   lane_sel;

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign accept    = req_valid && req_ready;
  assign wb_en     = (st == ST_WORK) && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      lane_q  <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
      mode_q  <= PRIO_PLAIN;
      rdata_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_WORK;
          wr_q    <= req_write;
          wide_q  <= req_wide;
          lane_q  <= req_addr[1:0];
          idx_q   <= req_addr[ADDR_W-1:2];
          wdata_q <= req_wdata;
          mode_q  <= prio_e'(req_prio);
        end
        ST_WORK: begin
          if (wr_q) begin
            st <= ST_IDLE;
          end else begin
            st      <= ST_RESP;
            rdata_q <= rd_expanded;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  ppr_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rd_en   (accept),
    .rd_idx  (req_addr[ADDR_W-1:2]),
    .rd_word (old_word),
    .wr_en   (wb_en),
    .wr_idx  (idx_q),
    .wr_word (wb_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int          HI = WORD_W - 1 - PIX_W * g;
    localparam logic [1:0]  LN = 2'(g);
    logic [PIX_W-1:0] new_pix;
    assign lane_sel[g] = wide_q ? (lane_q[1] == LN[1]) : (lane_q == LN);
    assign new_pix     = !wide_q ? wdata_q[PIX_W-1:0]
                       : (LN[0] ? wdata_q[3:0] : wdata_q[11:8]);
    ppr_pix_merge u_merge (
      .mode    (mode_q),
      .sel     (lane_sel[g]),
      .old_pix (old_word[HI -: PIX_W]),
      .new_pix (new_pix),
      .out_pix (wb_word[HI -: PIX_W])
    );
  end

  ppr_read_expand u_expand (
    .word (old_word),
    .lane (lane_q),
    .wide (wide_q),
    .data (rd_expanded)
  );

  // R4: zero pixel in overwrite mode leaves the word as fetched
  assert_over_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && mode_q == PRIO_OVER && !wide_q && wdata_q[3:0] == 4'h0)
      |-> (wb_word == old_word))
    else $error("overwrite-mode zero write changed the word");

  // R5: underwrite onto a set pixel leaves the word as fetched
  assert_under_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && mode_q == PRIO_UNDER && !wide_q && pix_at(old_word, lane_q) != 4'h0)
      |-> (wb_word == old_word))
    else $error("underwrite-mode write hit a set pixel");

  // R9: a write frees the request port after one busy cycle
  assert_write_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (!req_ready && !rsp_valid) ##1 req_ready)
    else $error("write busy window wrong");

  // R9: a read presents data on the second edge after acceptance
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !rsp_valid ##1 rsp_valid)
    else $error("read latency wrong");

  // R10: a stalled response stays unchanged
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && !req_ready))
    else $error("stalled response changed");

  // R9: request port closed while a response is pending
  assert_busy_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready)
    else $error("request port open during response");
endmodule

// File: tb/ppr_frame_store_bench.sv
module ppr_frame_store_bench;
  localparam int WORDS  = 256;
  localparam int ADDR_W = $clog2(WORDS) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_prio = 2'b00;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ppr_frame_store #(.WORDS(WORDS)) u_ppr_frame_store (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_prio(req_prio), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic [1:0]        mode;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       wdata;
    logic [15:0]       exp;
    logic [7:0]        rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'b00, 10'd0, 16'h000A, 16'h0000, 8'd1},  // R1 pixel 0
    '{1'b1, 1'b0, 2'b00, 10'd1, 16'h00F3, 16'h0000, 8'd2},  // R2 truncation
    '{1'b1, 1'b0, 2'b00, 10'd2, 16'h0005, 16'h0000, 8'd1},
    '{1'b1, 1'b0, 2'b00, 10'd3, 16'h0000, 16'h0000, 8'd3},
    '{1'b0, 1'b0, 2'b00, 10'd0, 16'h0000, 16'h000A, 8'd8},  // R8
    '{1'b0, 1'b0, 2'b00, 10'd1, 16'h0000, 16'h0003, 8'd2},  // R2
    '{1'b0, 1'b1, 2'b00, 10'd0, 16'h0000, 16'h0A03, 8'd7},  // R7 low pair
    '{1'b0, 1'b1, 2'b00, 10'd2, 16'h0000, 16'h0500, 8'd7},  // R7 high pair
    '{1'b0, 1'b1, 2'b00, 10'd3, 16'h0000, 16'h0500, 8'd7},  // R7 bit0 ignored
    '{1'b1, 1'b0, 2'b10, 10'd0, 16'h0000, 16'h0000, 8'd4},  // R4 zero dropped
    '{1'b0, 1'b0, 2'b00, 10'd0, 16'h0000, 16'h000A, 8'd4},
    '{1'b1, 1'b0, 2'b10, 10'd0, 16'h0007, 16'h0000, 8'd4},  // R4 nonzero stored
    '{1'b0, 1'b0, 2'b00, 10'd0, 16'h0000, 16'h0007, 8'd4},
    '{1'b1, 1'b0, 2'b01, 10'd3, 16'h0009, 16'h0000, 8'd5},  // R5 fills zero
    '{1'b0, 1'b0, 2'b00, 10'd3, 16'h0000, 16'h0009, 8'd5},
    '{1'b1, 1'b0, 2'b01, 10'd3, 16'h0004, 16'h0000, 8'd5},  // R5 set pixel kept
    '{1'b0, 1'b0, 2'b00, 10'd3, 16'h0000, 16'h0009, 8'd5},
    '{1'b1, 1'b0, 2'b01, 10'd2, 16'h0000, 16'h0000, 8'd5},  // R5 zero dropped
    '{1'b0, 1'b0, 2'b00, 10'd2, 16'h0000, 16'h0005, 8'd5},
    '{1'b1, 1'b0, 2'b11, 10'd2, 16'h0000, 16'h0000, 8'd3},  // R3 mode 11 zero
    '{1'b0, 1'b0, 2'b00, 10'd2, 16'h0000, 16'h0000, 8'd3},
    '{1'b1, 1'b1, 2'b00, 10'd5, 16'h1C2D, 16'h0000, 8'd6},  // R6 bit0 ignored
    '{1'b0, 1'b1, 2'b00, 10'd4, 16'h0000, 16'h0C0D, 8'd6},
    '{1'b1, 1'b1, 2'b10, 10'd4, 16'h0900, 16'h0000, 8'd6},  // R6 overwrite pair
    '{1'b0, 1'b1, 2'b00, 10'd4, 16'h0000, 16'h090D, 8'd6},
    '{1'b1, 1'b1, 2'b00, 10'd6, 16'h0003, 16'h0000, 8'd6},
    '{1'b1, 1'b1, 2'b01, 10'd6, 16'h0506, 16'h0000, 8'd6},  // R6 underwrite split
    '{1'b0, 1'b1, 2'b00, 10'd6, 16'h0000, 16'h0503, 8'd6},
    '{1'b0, 1'b0, 2'b00, 10'd6, 16'h0000, 16'h0005, 8'd8},
    '{1'b0, 1'b0, 2'b00, 10'd7, 16'h0000, 16'h0003, 8'd8},
    '{1'b0, 1'b1, 2'b00, 10'd0, 16'h0000, 16'h0703, 8'd1},  // R1 neighbours intact
    '{1'b0, 1'b1, 2'b00, 10'd4, 16'h0000, 16'h090D, 8'd1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic wide, input logic [1:0] mode,
                       input logic [ADDR_W-1:0] addr, input logic [15:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_prio = mode; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xfer(input logic wr, input logic wide, input logic [1:0] mode,
                      input logic [ADDR_W-1:0] addr, input logic [15:0] wd,
                      output logic [15:0] rd);
    issue(wr, wide, mode, addr, wd);
    rd = '0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R11: reset state while reset held
    check("R11 ready in reset", {15'd0, req_ready}, 16'd1);
    check("R11 rsp_valid in reset", {15'd0, rsp_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", {15'd0, req_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].wide, VECS[i].mode, VECS[i].addr, VECS[i].wdata, rd);
      if (!VECS[i].wr)
        check($sformatf("R%0d vector %0d", VECS[i].rq, i), rd, VECS[i].exp);
    end

    // R9: write handshake timing
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0; req_prio = 2'b00;
    req_addr = 10'd8; req_wdata = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after write", {15'd0, req_ready}, 16'd0);
    @(negedge clk);
    check("R9 free after write", {15'd0, req_ready}, 16'd1);

    // R9 and R10: read latency and held response
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'd8;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 no data one cycle after accept", {15'd0, rsp_valid}, 16'd0);
    @(negedge clk);
    check("R9 data two cycles after accept", {15'd0, rsp_valid}, 16'd1);
    check("R8 read value", rsp_rdata, 16'h0001);
    repeat (3) @(negedge clk);
    check("R10 valid held", {15'd0, rsp_valid}, 16'd1);
    check("R10 data held", rsp_rdata, 16'h0001);
    check("R10 port closed", {15'd0, req_ready}, 16'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 released", {14'd0, rsp_valid, req_ready}, 16'd1);

    // R1: last word of the memory
    xfer(1'b1, 1'b1, 2'b00, 10'h3FE, 16'h0B06, rd);
    xfer(1'b1, 1'b0, 2'b00, 10'h3FF, 16'h000E, rd);
    xfer(1'b0, 1'b1, 2'b00, 10'h3FE, 16'h0000, rd);
    check("R1 last word", rd, 16'h0B0E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule